// File: doc/BRIEF.md
# Write-Only I2C Register Target

This block is a synchronous I2C target that only accepts writes. SCL and SDA are sampled by the system clock and each line goes through a short synchroniser. A persistence filter then removes short pulses before the bus events are decoded. The system clock must run at least sixteen times faster than SCL, so a 400 kHz bus needs a clock of 6.4 MHz or more.

A transfer opens with START, followed by an address byte. When that byte names this target with the write direction, the target acknowledges it by pulling SDA low. It then takes in any number of data bytes and acknowledges each one. Every acknowledged data byte appears on the fabric side as a one-cycle strobe together with its 8-bit value. There is no sub-address byte: the consumer reads the byte stream in order. One bit of the target's address comes from a strap pin, so two such targets can share a bus.

Top module: `i2c_wr_target`

## Requirements
- R1: While reset is high and in the cycle after it, `sda_oe` and `byte_vld` are both 0.
- R2: After START (SDA falling while SCL is high), the target samples eight bits on rising SCL edges, MSB first. If the byte equals 1,1,0,1,1,0,`addr_strap`,0 (bit 7 to bit 0, where bit 0 = 0 means write), `sda_oe` goes high after the following SCL fall and stays high through the ninth SCL high phase. `sda_oe` changes only while the filtered SCL is low.
- R3: Any other address byte, whether it names the other strap value or has bit 0 = 1 (read), is not acknowledged. Bytes that follow it get no acknowledge and no strobe until the next START.
- R4: After a matched address, every 8-bit data byte is acknowledged, with no limit on their number. Each one gives exactly one `byte_vld` pulse of a single cycle, with `byte_data` holding the byte MSB-first.
- R5: STOP (SDA rising while SCL is high) releases `sda_oe` and ends the transfer. Bytes clocked afterwards without a new START are neither acknowledged nor strobed.
- R6: A START in the middle of a byte clears the bit count and restarts address reception.
- R7: `byte_vld` fires only for a data byte that was fully received and acknowledged. It fires during the acknowledge clock, while `sda_oe` is high. A byte cut short by START or STOP produces no strobe.
- R8: A pulse on SCL shorter than `FILT_LEN` system clocks is ignored and does not count as a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND) |
| addr_strap | input | 1 | Strap pin giving address bit 1 of the byte |
| sda_oe | output | 1 | Pull-down enable for SDA (open drain) |
| byte_vld | output | 1 | One-cycle strobe for an accepted data byte |
| byte_data | output | 8 | Value of the last accepted data byte |

## Verification
Two events can fall in the same cycle: the data-byte strobe and the acknowledge pull-down. The strobe is raised on the rising edge of the ninth clock, while `sda_oe` is still asserted. Long byte streams provoke this overlap, and the bench reads the acknowledge level in the middle of that high phase and counts the strobes. START and STOP can also hit the byte engine in the middle of a byte. The bench cuts data bytes short with each of them and checks that no strobe appears and that the next address is received cleanly.

// File: rtl/i2c_wr_pkg.sv
package i2c_wr_pkg;

    // Fixed upper six bits of the 7-bit target address
    localparam logic [5:0] ADDR_FIXED = 6'b110110;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK_SETUP,
        ST_ACK_HOLD,
        ST_ACK_DONE,
        ST_IGNORE
    } tgt_state_e;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    // Address byte that selects this target for a write
    function automatic logic [7:0] own_wr_byte(input logic strap);
        return {ADDR_FIXED, strap, 1'b0};
    endfunction

endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CW-1:0]          cnt_q;
    logic                   filt_q;
    logic                   synced;

    assign synced = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '1;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
    end

    // The output follows the input only after FILT_LEN differing samples in a row
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else if (synced == filt_q) begin
            cnt_q <= '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            filt_q <= synced;
            cnt_q  <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign line_o = filt_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events
    import i2c_wr_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_f,
    input  logic    sda_f,
    output bus_ev_t ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        ev.scl_rise = !scl_q && scl_f;
        ev.scl_fall = scl_q && !scl_f;
        ev.start    = scl_q && scl_f && sda_q && !sda_f;
        ev.stop     = scl_q && scl_f && !sda_q && sda_f;
        ev.sda      = sda_f;
    end
endmodule

// File: rtl/i2c_wr_engine.sv
module i2c_wr_engine
    import i2c_wr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic       strap,
    output logic       sda_oe,
    output logic       byte_vld,
    output logic [7:0] byte_data
);
    tgt_state_e state_q;
    logic [2:0] bit_cnt_q;
    logic [7:0] shreg_q;
    logic       in_data_q;
    logic       addr_hit;

    assign addr_hit = (shreg_q == own_wr_byte(strap));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            bit_cnt_q <= '0;
            shreg_q   <= '0;
            in_data_q <= 1'b0;
            sda_oe    <= 1'b0;
            byte_vld  <= 1'b0;
            byte_data <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (ev.start) begin
                state_q   <= ST_RX;
                bit_cnt_q <= '0;
                in_data_q <= 1'b0;
                sda_oe    <= 1'b0;
            end else if (ev.stop) begin
                state_q <= ST_IDLE;
                sda_oe  <= 1'b0;
            end else begin
                case (state_q)
                    ST_RX: if (ev.scl_rise) begin
                        shreg_q   <= {shreg_q[6:0], ev.sda};
                        bit_cnt_q <= bit_cnt_q + 1'b1;
                        if (bit_cnt_q == 3'd7) state_q <= ST_ACK_SETUP;
                    end
                    ST_ACK_SETUP: if (ev.scl_fall) begin
                        if (in_data_q || addr_hit) begin
                            sda_oe  <= 1'b1;
                            state_q <= ST_ACK_HOLD;
                        end else begin
                            state_q <= ST_IGNORE;
                        end
                    end
                    ST_ACK_HOLD: if (ev.scl_rise) begin
                        if (in_data_q) begin
                            byte_vld  <= 1'b1;
                            byte_data <= shreg_q;
                        end
                        state_q <= ST_ACK_DONE;
                    end
                    ST_ACK_DONE: if (ev.scl_fall) begin
                        sda_oe    <= 1'b0;
                        in_data_q <= 1'b1;
                        state_q   <= ST_RX;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_wr_target.sv
module i2c_wr_target
    import i2c_wr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       addr_strap,
    output logic       sda_oe,
    output logic       byte_vld,
    output logic [7:0] byte_data
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw;
    logic [N_LINES-1:0] line_filt;
    bus_ev_t            bus_ev;

    assign line_raw = {scl_i, sda_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2c_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk   (clk),
            .rst   (rst),
            .line_i(line_raw[g]),
            .line_o(line_filt[g])
        );
    end

    i2c_bus_events u_events (
        .clk  (clk),
        .rst  (rst),
        .scl_f(line_filt[1]),
        .sda_f(line_filt[0]),
        .ev   (bus_ev)
    );

    i2c_wr_engine u_engine (
        .clk      (clk),
        .rst      (rst),
        .ev       (bus_ev),
        .strap    (addr_strap),
        .sda_oe   (sda_oe),
        .byte_vld (byte_vld),
        .byte_data(byte_data)
    );
endmodule

// File: rtl/i2c_wr_target_chk.sv
module i2c_wr_target_chk
    import i2c_wr_pkg::*;
(
    input logic    clk,
    input logic    rst,
    input logic    sda_oe,
    input logic    byte_vld,
    input logic    scl_f,
    input bus_ev_t ev
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!sda_oe && !byte_vld));

    assert_oe_moves_scl_low_R2: assert property (@(posedge clk) disable iff (rst)
        (sda_oe != $past(sda_oe)) |-> !$past(scl_f));

    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        byte_vld |=> !byte_vld);

    assert_stop_releases_R5: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

    assert_strobe_in_ack_R7: assert property (@(posedge clk) disable iff (rst)
        byte_vld |-> sda_oe);
endmodule

bind i2c_wr_target i2c_wr_target_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .sda_oe  (sda_oe),
    .byte_vld(byte_vld),
    .scl_f   (line_filt[1]),
    .ev      (bus_ev)
);

// File: tb/i2c_wr_target_tb.sv
module i2c_wr_target_tb;
    localparam int Q = 20; // system clocks per quarter SCL bit

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_h = 1'b1;
    logic       sda_h = 1'b1;
    logic       strap = 1'b0;
    logic       sda_oe, byte_vld;
    logic [7:0] byte_data;
    logic       sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int cap_n = 0;
    logic [7:0] cap [0:63];

    assign sda_bus = sda_h & ~sda_oe;

    always #2 clk = ~clk;

    i2c_wr_target u_dut (
        .clk       (clk),
        .rst       (rst),
        .scl_i     (scl_h),
        .sda_i     (sda_bus),
        .addr_strap(strap),
        .sda_oe    (sda_oe),
        .byte_vld  (byte_vld),
        .byte_data (byte_data)
    );

    always @(negedge clk) begin
        if (!rst && byte_vld) begin
            if (cap_n < 64) cap[cap_n] = byte_data;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wait_q();
        scl_h = 1'b1; wait_q();
        sda_h = 1'b0; wait_q();
        scl_h = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wait_q();
        scl_h = 1'b1; wait_q();
        sda_h = 1'b1; wait_q();
    endtask

    task automatic bit_out(input logic b);
        sda_h = b; wait_q();
        scl_h = 1'b1; wait_q(); wait_q();
        scl_h = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_h = 1'b1; wait_q();
        scl_h = 1'b1; wait_q();
        acked = (sda_oe === 1'b1) && (sda_bus === 1'b0);
        wait_q();
        scl_h = 1'b0; wait_q();
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1 sda_oe in reset", sda_oe, 0);
        chk("R1 byte_vld in reset", byte_vld, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 sda_oe after reset", sda_oe, 0);
    endtask

    task automatic t_stream();
        logic a;
        logic [7:0] vals [4] = '{8'h5A, 8'hA5, 8'h00, 8'hFF};
        int base = cap_n;
        strap = 1'b0;
        bus_start();
        send_byte(8'hD8, a); chk("R2 address ack strap0", a, 1);
        for (int k = 0; k < 4; k++) begin
            send_byte(vals[k], a); chk("R4 data ack", a, 1);
        end
        bus_stop();
        chk("R4 strobe count", cap_n - base, 4);
        for (int k = 0; k < 4; k++) chk("R4 strobe value", cap[base + k], vals[k]);
        chk("R5 released after stop", sda_oe, 0);
    endtask

    task automatic t_strap();
        logic a;
        int base = cap_n;
        strap = 1'b1;
        wait_q();
        bus_start();
        send_byte(8'hDA, a); chk("R2 address ack strap1", a, 1);
        send_byte(8'h3C, a); chk("R4 data ack strap1", a, 1);
        bus_stop();
        chk("R4 strobe strap1", cap[base], 8'h3C);
        bus_start();
        send_byte(8'hD8, a); chk("R3 wrong strap nack", a, 0);
        send_byte(8'h11, a); chk("R3 byte after nack", a, 0);
        bus_stop();
        strap = 1'b0;
        wait_q();
        bus_start();
        send_byte(8'hD9, a); chk("R3 read bit nack", a, 0);
        send_byte(8'h22, a); chk("R3 byte after read nack", a, 0);
        bus_stop();
        chk("R3 no strobe after mismatch", cap_n - base, 1);
    endtask

    task automatic t_restart();
        logic a;
        int base = cap_n;
        bus_start();
        send_byte(8'hD8, a);
        for (int i = 0; i < 4; i++) bit_out(1'b1);
        bus_start();
        chk("R7 no strobe for cut byte", cap_n - base, 0);
        send_byte(8'hD8, a); chk("R6 address after restart", a, 1);
        send_byte(8'h81, a); chk("R6 data after restart", a, 1);
        bus_stop();
        chk("R6 one strobe", cap_n - base, 1);
        chk("R6 strobe value", cap[base], 8'h81);
    endtask

    task automatic t_stop_cut();
        logic a;
        int base = cap_n;
        bus_start();
        send_byte(8'hD8, a);
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b0);
        bus_stop();
        chk("R7 no strobe after stop cut", cap_n - base, 0);
        scl_h = 1'b0; wait_q();
        send_byte(8'hD8, a); chk("R5 no ack without start", a, 0);
        send_byte(8'h44, a); chk("R5 no data ack without start", a, 0);
        bus_stop();
        chk("R5 no strobe without start", cap_n - base, 0);
    endtask

    task automatic t_glitch();
        logic a;
        logic [7:0] b = 8'h96;
        int base = cap_n;
        bus_start();
        send_byte(8'hD8, a);
        for (int i = 7; i >= 0; i--) begin
            sda_h = b[i]; wait_q();
            if (i == 4) begin
                scl_h = 1'b1; repeat (2) @(negedge clk);
                scl_h = 1'b0; wait_q();
            end
            scl_h = 1'b1; wait_q(); wait_q();
            scl_h = 1'b0; wait_q();
        end
        sda_h = 1'b1; wait_q();
        scl_h = 1'b1; wait_q();
        a = (sda_oe === 1'b1);
        wait_q();
        scl_h = 1'b0; wait_q();
        bus_stop();
        chk("R8 ack despite glitch", a, 1);
        chk("R8 strobe count", cap_n - base, 1);
        chk("R8 value intact", cap[base], b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired, actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_stream();
        t_strap();
        t_restart();
        t_stop_cut();
        t_glitch();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule